// File: doc/BRIEF.md
# Transverse Energy Vector Projector

On every bunch-crossing clock the block accepts a set of per-region transverse energy values. Each value is turned into an X and a Y component by table lookup. The block then sums the components across all regions and delivers a total Ex, a total Ey and a scalar ET sum. The X and Y lookups hold precomputed value-times-cosine and value-times-sine products. These live in writable on-chip RAM tables, one table per region and per axis, indexed by the energy value. A host can therefore change the projection coefficients at run time without rebuilding the design.

The host reaches the tables through a small two-register bus. One register holds an auto-advancing table pointer. The other is a data window: every read or write through it touches the table entry under the pointer, and the pointer then steps to the next entry. A whole table set can be streamed in or out with one pointer write followed by consecutive data accesses.

The data path is a fixed pipeline. A new input can be accepted every clock, and its result leaves a constant number of clocks later together with a valid flag.

Top module: `et_vector_projector`

## Requirements
- R1: `out_ex` equals the sum, over all regions, of the X-table entry selected by each region's energy. `out_ey` is the same sum taken over the Y tables. Table entries are signed C_W-bit values.
- R2: `out_et` equals the unsigned sum of all input energy values.
- R3: A valid input sampled on one clock edge produces `out_valid` high with its sums on the fourth clock edge after that edge. Back-to-back inputs produce back-to-back results. An input sampled with `in_valid` low produces `out_valid` low at the same distance.
- R4: Sums beyond the SUM_W range saturate rather than wrap. The signed X and Y sums clamp to the signed SUM_W-bit limits, and ET clamps to the unsigned SUM_W-bit maximum.
- R5: The pointer has the layout {region, axis, entry}. The entry is the low E_W bits, the axis bit comes next (0 selects the X table, 1 the Y table), and the region sits above it. A write with `host_sel`=0 loads the pointer from `host_wdata`. A read with `host_sel`=0 returns the pointer zero-extended and leaves it unchanged.
- R6: A write with `host_sel`=1 stores the low C_W bits of `host_wdata` into the entry under the pointer. A read with `host_sel`=1 returns that entry sign-extended to 16 bits. `host_rvalid` is high for exactly one cycle, and it is set on the second clock edge counting the edge that sampled the read. After each data access the pointer advances by one.
- R7: The pointer wraps from its all-ones value to zero.
- R8: When a host write and a data-path lookup hit the same table entry on the same clock edge, the data path receives the entry's previous contents.
- R9: After reset, `out_valid` and `host_rvalid` are low, the sum outputs are zero and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input energy set is valid this cycle |
| in_energy | input | N_CH*E_W | Region energies, region c at bits [c*E_W +: E_W] |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 = pointer register, 1 = table data window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rvalid | output | 1 | Host read data valid |
| out_valid | output | 1 | Output sums valid |
| out_ex | output | SUM_W | Saturated signed X sum |
| out_ey | output | SUM_W | Saturated signed Y sum |
| out_et | output | SUM_W | Saturated unsigned scalar ET sum |

## Verification
The tables are loaded with a coefficient pattern of mixed sign that differs for each region and axis. A table of ramp, flat-maximum, all-zero, descending and sparse energy patterns is then streamed back to back with one invalid slot among them. The ramps catch swapped regions or axes. The flat patterns and the sparse pattern catch a wrong table index or stale lookups. The invalid slot shows that the valid flag and the sums stay aligned. A second instance with narrow sums receives the same patterns and drives both signed limits and the unsigned limit into saturation. Directed tests cover pointer readback, a boundary crossing between regions, wrap-around, and a write that collides with a lookup of the same entry.

// File: rtl/etvp_pkg.sv
package etvp_pkg;
  localparam int HOST_W = 16;
  localparam logic SEL_PTR  = 1'b0;
  localparam logic SEL_DATA = 1'b1;
endpackage

// File: rtl/etvp_coef_ram.sv
// One coefficient table: port A is the data-path lookup, port B the host port.
// Both ports read-first, so a same-edge write is not seen by the lookup.
module etvp_coef_ram #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) a_q <= mem[a_addr];

  always_ff @(posedge clk) begin
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
      b_q <= mem[b_addr];
    end
  end
endmodule

// File: rtl/etvp_host_ctrl.sv
module etvp_host_ctrl
  import etvp_pkg::*;
#(
  parameter int N_CH = 16,
  parameter int E_W  = 8,
  parameter int C_W  = 12,
  localparam int CH_W  = $clog2(N_CH),
  localparam int SEL_W = CH_W + 1,
  localparam int PTR_W = SEL_W + E_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              tb_en,
  output logic              tb_we,
  output logic [E_W-1:0]    tb_addr,
  output logic [SEL_W-1:0]  tb_sel,
  output logic [C_W-1:0]    tb_wdata,
  output logic [SEL_W-1:0]  rd_sel_q,
  input  logic [C_W-1:0]    tb_rdata
);
  logic [PTR_W-1:0] ptr, ptr_snap;
  logic             rd_pend, rd_is_ptr;
  logic             data_acc;

  assign data_acc = (host_wr | host_rd) & (host_sel == SEL_DATA);
  assign tb_en    = data_acc;
  assign tb_we    = host_wr;
  assign tb_addr  = ptr[E_W-1:0];
  assign tb_sel   = ptr[PTR_W-1:E_W];
  assign tb_wdata = host_wdata[C_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr         <= '0;
      ptr_snap    <= '0;
      rd_pend     <= 1'b0;
      rd_is_ptr   <= 1'b0;
      rd_sel_q    <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      if (host_wr && host_sel == SEL_PTR) ptr <= host_wdata[PTR_W-1:0];
      else if (data_acc)                  ptr <= ptr + 1'b1;
      rd_pend     <= host_rd & ~host_wr;
      rd_is_ptr   <= (host_sel == SEL_PTR);
      rd_sel_q    <= tb_sel;
      ptr_snap    <= ptr;
      host_rvalid <= rd_pend;
      if (rd_pend)
        host_rdata <= rd_is_ptr ? HOST_W'(ptr_snap)
                                : {{(HOST_W-C_W){tb_rdata[C_W-1]}}, tb_rdata};
    end
  end

  // R5: every data access steps the pointer by one
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
    data_acc |=> (ptr == $past(ptr) + 1'b1));
  // R7: all-ones pointer wraps to zero
  a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (data_acc && ptr == '1) |=> (ptr == '0));
  // R6: read data flagged two edges after the request
  a_r6_rvalid: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr) |-> ##2 host_rvalid);
endmodule

// File: rtl/etvp_accum.sv
module etvp_accum #(
  parameter int N_CH  = 16,
  parameter int E_W   = 8,
  parameter int C_W   = 12,
  parameter int SUM_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vld_i,
  input  logic signed [C_W-1:0] cx_i [N_CH],
  input  logic signed [C_W-1:0] cy_i [N_CH],
  input  logic [E_W-1:0]        e_i  [N_CH],
  output logic                  vld_o,
  output logic [SUM_W-1:0]      ex_o,
  output logic [SUM_W-1:0]      ey_o,
  output logic [SUM_W-1:0]      et_o
);
  localparam int LG     = $clog2(N_CH);
  localparam int SACC_W = (C_W + LG + 1 > SUM_W + 1) ? C_W + LG + 1 : SUM_W + 1;
  localparam int UACC_W = (E_W + LG + 1 > SUM_W + 1) ? E_W + LG + 1 : SUM_W + 1;
  localparam logic signed [SACC_W-1:0] SMAX = SACC_W'((longint'(1) <<< (SUM_W-1)) - 1);
  localparam logic signed [SACC_W-1:0] SMIN = -SMAX - 1;
  localparam logic [UACC_W-1:0]        UMAX = UACC_W'((longint'(1) << SUM_W) - 1);

  logic signed [SACC_W-1:0] sx_n, sy_n, sx_q, sy_q;
  logic [UACC_W-1:0]        st_n, st_q;
  logic                     va_q;

  always_comb begin
    sx_n = '0;
    sy_n = '0;
    st_n = '0;
    for (int i = 0; i < N_CH; i++) begin
      sx_n = sx_n + SACC_W'(cx_i[i]);
      sy_n = sy_n + SACC_W'(cy_i[i]);
      st_n = st_n + UACC_W'(e_i[i]);
    end
  end

  function automatic logic [SUM_W-1:0] clamp_s(input logic signed [SACC_W-1:0] v);
    if (v > SMAX)      return SMAX[SUM_W-1:0];
    else if (v < SMIN) return SMIN[SUM_W-1:0];
    else               return v[SUM_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q  <= 1'b0;
      sx_q  <= '0;
      sy_q  <= '0;
      st_q  <= '0;
      vld_o <= 1'b0;
      ex_o  <= '0;
      ey_o  <= '0;
      et_o  <= '0;
    end else begin
      va_q  <= vld_i;
      sx_q  <= sx_n;
      sy_q  <= sy_n;
      st_q  <= st_n;
      vld_o <= va_q;
      ex_o  <= clamp_s(sx_q);
      ey_o  <= clamp_s(sy_q);
      et_o  <= (st_q > UMAX) ? UMAX[SUM_W-1:0] : st_q[SUM_W-1:0];
    end
  end

  // R4: overflowing sums land on the limit, never on wrapped bits
  a_r4_sat_hi: assert property (@(posedge clk) disable iff (rst)
    (sx_q > SMAX) |=> (ex_o == SMAX[SUM_W-1:0]));
  a_r4_sat_lo: assert property (@(posedge clk) disable iff (rst)
    (sy_q < SMIN) |=> (ey_o == SMIN[SUM_W-1:0]));
  a_r4_et_cap: assert property (@(posedge clk) disable iff (rst)
    (st_q > UMAX) |=> (et_o == UMAX[SUM_W-1:0]));
endmodule

// File: rtl/et_vector_projector.sv
module et_vector_projector
  import etvp_pkg::*;
#(
  parameter int N_CH  = 16,
  parameter int E_W   = 8,
  parameter int C_W   = 12,
  parameter int SUM_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [N_CH*E_W-1:0] in_energy,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic                host_sel,
  input  logic [HOST_W-1:0]   host_wdata,
  output logic [HOST_W-1:0]   host_rdata,
  output logic                host_rvalid,
  output logic                out_valid,
  output logic [SUM_W-1:0]    out_ex,
  output logic [SUM_W-1:0]    out_ey,
  output logic [SUM_W-1:0]    out_et
);
  localparam int CH_W  = $clog2(N_CH);
  localparam int SEL_W = CH_W + 1;
  localparam int N_TBL = 2 * N_CH;

  logic                  v1, v2;
  logic [E_W-1:0]        e1 [N_CH];
  logic [E_W-1:0]        e2 [N_CH];
  logic signed [C_W-1:0] cx [N_CH];
  logic signed [C_W-1:0] cy [N_CH];
  logic [C_W-1:0]        bq [N_TBL];

  logic             tb_en, tb_we;
  logic [E_W-1:0]   tb_addr;
  logic [SEL_W-1:0] tb_sel, rd_sel_q;
  logic [C_W-1:0]   tb_wdata, tb_rdata;

  // Stage 1: register inputs; stage 2: table lookup with aligned energies
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
    for (int c = 0; c < N_CH; c++) begin
      e1[c] <= in_energy[c*E_W +: E_W];
      e2[c] <= e1[c];
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    for (genvar a = 0; a < 2; a++) begin : g_ax
      localparam int TI = c * 2 + a;
      logic [C_W-1:0] qa;
      etvp_coef_ram #(.AW(E_W), .DW(C_W)) u_ram (
        .clk     (clk),
        .a_addr  (e1[c]),
        .a_q     (qa),
        .b_en    (tb_en && (tb_sel == SEL_W'(TI))),
        .b_we    (tb_we),
        .b_addr  (tb_addr),
        .b_wdata (tb_wdata),
        .b_q     (bq[TI])
      );
      if (a == 0) begin : g_x
        assign cx[c] = qa;
      end else begin : g_y
        assign cy[c] = qa;
      end
    end
  end

  assign tb_rdata = bq[rd_sel_q];

  etvp_host_ctrl #(.N_CH(N_CH), .E_W(E_W), .C_W(C_W)) u_host (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_sel    (host_sel),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .tb_en       (tb_en),
    .tb_we       (tb_we),
    .tb_addr     (tb_addr),
    .tb_sel      (tb_sel),
    .tb_wdata    (tb_wdata),
    .rd_sel_q    (rd_sel_q),
    .tb_rdata    (tb_rdata)
  );

  etvp_accum #(.N_CH(N_CH), .E_W(E_W), .C_W(C_W), .SUM_W(SUM_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .vld_i (v2),
    .cx_i  (cx),
    .cy_i  (cy),
    .e_i   (e2),
    .vld_o (out_valid),
    .ex_o  (out_ex),
    .ey_o  (out_ey),
    .et_o  (out_et)
  );

  // R3: valid flag emerges exactly four edges after it was sampled
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 1'b1;
  end
  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));
endmodule

// File: tb/et_vector_projector_bench.sv
module et_vector_projector_bench;
  localparam int N_CH = 16;
  localparam int E_W  = 8;
  localparam int NV   = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic [N_CH*E_W-1:0] in_energy = '0;
  logic                host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
  logic [15:0]         host_wdata = '0;
  logic [15:0]         host_rdata, n_rdata;
  logic                host_rvalid, n_rvalid;
  logic                out_valid, n_valid;
  logic [15:0]         out_ex, out_ey, out_et;
  logic [10:0]         n_ex, n_ey, n_et;

  et_vector_projector u_et_vector_projector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_energy(in_energy),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .out_valid(out_valid), .out_ex(out_ex), .out_ey(out_ey), .out_et(out_et));

  // Narrow-sum copy sharing every input, used to reach saturation (R4)
  et_vector_projector #(.SUM_W(11)) u_et_vector_projector_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_energy(in_energy),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rdata(n_rdata), .host_rvalid(n_rvalid),
    .out_valid(n_valid), .out_ex(n_ex), .out_ey(n_ey), .out_et(n_et));

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int coef(input int ch, input int ax, input int e);
    logic [11:0] raw;
    raw = 12'(e * 37 + ch * 211 + ax * 1001 + (e * e) % 97);
    return int'($signed(raw));
  endfunction

  function automatic int idx(input int ch, input int ax, input int e);
    return ch * 512 + ax * 256 + e;
  endfunction

  function automatic int clamp(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic int en_of(input logic [N_CH*E_W-1:0] en, input int ch);
    return int'(en[ch*E_W +: E_W]);
  endfunction

  function automatic int sum_ax(input logic [N_CH*E_W-1:0] en, input int ax);
    int s = 0;
    for (int c = 0; c < N_CH; c++) s += coef(c, ax, en_of(en, c));
    return s;
  endfunction

  function automatic int sum_et(input logic [N_CH*E_W-1:0] en);
    int s = 0;
    for (int c = 0; c < N_CH; c++) s += en_of(en, c);
    return s;
  endfunction

  // {valid, base, step}: region c gets (base + step*c) mod 256
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'd0,   8'd0},
    {1'b1, 8'd255, 8'd0},
    {1'b1, 8'd0,   8'd17},
    {1'b0, 8'd77,  8'd3},
    {1'b1, 8'd128, 8'd1},
    {1'b1, 8'd255, 8'd255},
    {1'b1, 8'd3,   8'd85},
    {1'b1, 8'd200, 8'd0}
  };

  function automatic logic [N_CH*E_W-1:0] vec_en(input int i);
    logic [N_CH*E_W-1:0] en;
    for (int c = 0; c < N_CH; c++) en[c*E_W +: E_W] = 8'(VEC[i][15:8] + VEC[i][7:0] * c);
    return en;
  endfunction

  task automatic host_write(input logic sel, input int data);
    host_wr = 1'b1; host_sel = sel; host_wdata = 16'(data);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic sel, output int val, output int vld);
    host_rd = 1'b1; host_sel = sel;
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    val = int'($signed(host_rdata));
    vld = int'(host_rvalid);
  endtask

  task automatic check_sums(input string tag, input logic [N_CH*E_W-1:0] en);
    check({tag, " R1 ex"}, int'($signed(out_ex)), clamp(sum_ax(en, 0), -32768, 32767));
    check({tag, " R1 ey"}, int'($signed(out_ey)), clamp(sum_ax(en, 1), -32768, 32767));
    check({tag, " R2 et"}, int'(out_et), clamp(sum_et(en), 0, 65535));
    check({tag, " R4 narrow ex"}, int'($signed(n_ex)), clamp(sum_ax(en, 0), -1024, 1023));
    check({tag, " R4 narrow ey"}, int'($signed(n_ey)), clamp(sum_ax(en, 1), -1024, 1023));
    check({tag, " R4 narrow et"}, int'(n_et), clamp(sum_et(en), 0, 2047));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, vl, oldx, newx;
    logic [N_CH*E_W-1:0] sev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 out_ex", int'(out_ex), 0);
    check("R9 out_et", int'(out_et), 0);
    check("R9 host_rvalid", int'(host_rvalid), 0);
    host_read(1'b0, v, vl);
    check("R9 pointer", v, 0);

    // Load every table by streaming through the data window (R5/R6)
    host_write(1'b0, 0);
    for (int ch = 0; ch < N_CH; ch++)
      for (int ax = 0; ax < 2; ax++)
        for (int e = 0; e < 256; e++)
          host_write(1'b1, coef(ch, ax, e));
    host_read(1'b0, v, vl);
    check("R7 pointer wrapped after full load", v, 0);

    // R5/R6: readback across a region boundary
    host_write(1'b0, idx(3, 1, 254));
    host_read(1'b0, v, vl);
    check("R5 pointer readback", v, idx(3, 1, 254));
    host_read(1'b1, v, vl);
    check("R6 data read", v, coef(3, 1, 254));
    check("R6 rvalid", vl, 1);
    @(negedge clk);
    check("R6 rvalid single cycle", int'(host_rvalid), 0);
    host_read(1'b1, v, vl);
    check("R6 data read next", v, coef(3, 1, 255));
    host_read(1'b1, v, vl);
    check("R6 data read boundary", v, coef(4, 0, 0));
    host_read(1'b0, v, vl);
    check("R5 pointer advanced", v, idx(4, 0, 1));

    // R7: explicit wrap from the last entry
    host_write(1'b0, 16'h1FFF);
    host_write(1'b1, coef(15, 1, 255));
    host_read(1'b0, v, vl);
    check("R7 pointer wrap", v, 0);

    // Vector walk, back to back (R1 R2 R3 R4)
    for (int i = 0; i < NV + 4; i++) begin
      if (i >= 4) begin
        check($sformatf("vec%0d R3 valid", i - 4), int'(out_valid), int'(VEC[i-4][16]));
        check($sformatf("vec%0d R3 narrow valid", i - 4), int'(n_valid), int'(VEC[i-4][16]));
        if (VEC[i-4][16]) check_sums($sformatf("vec%0d", i - 4), vec_en(i - 4));
      end
      if (i < NV) begin
        in_valid  = VEC[i][16];
        in_energy = vec_en(i);
      end else begin
        in_valid  = 1'b0;
        in_energy = '0;
      end
      @(negedge clk);
    end

    // Sparse pattern: one region non-zero (R1)
    sev = '0;
    sev[5*E_W +: E_W] = 8'd99;
    in_valid = 1'b1; in_energy = sev;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("sparse R3 valid", int'(out_valid), 1);
    check_sums("sparse", sev);

    // R8: host write to an entry on the same edge as its lookup
    host_write(1'b0, idx(0, 0, 7));
    for (int c = 0; c < N_CH; c++) sev[c*E_W +: E_W] = 8'd7;
    oldx = sum_ax(sev, 0);
    newx = oldx - coef(0, 0, 7) + 291;
    in_valid = 1'b1; in_energy = sev;
    @(negedge clk);
    in_valid = 1'b0;
    host_wr = 1'b1; host_sel = 1'b1; host_wdata = 16'd291;
    @(negedge clk);
    host_wr = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 collision valid", int'(out_valid), 1);
    check("R8 lookup sees old entry", int'($signed(out_ex)), oldx);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 later lookup sees new entry", int'($signed(out_ex)), newx);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule